// File: doc/BRIEF.md
# Watchdog Timer with Power-Save Wake

This block is a watchdog counter that advances on a slow tick coming from a low-power oscillator. The tick is brought into the bus clock domain and only its rising edges count. Software keeps the watchdog quiet by writing a clear bit from time to time. A missed service ends in one of two ways, and the power mode decides which. While the system runs, the block sends a one-cycle device-reset request. While the system is in sleep or idle, it sends a one-cycle non-maskable wake interrupt instead, and it records the cause in sticky status flags.

Software uses a small register bus with two words. The control word holds the enable bit, a postscaler select field and the self-clearing clear bit. The status word holds the timeout, sleep-cause and idle-cause flags. A configuration input can pin the watchdog on so that no write and no reset turns it off. The block also drives an oscillator-enable output whenever the watchdog is in effect.

Top module: `wdt_pwrsave`

## Requirements
- R1: While `cfg_force_on` is 1, control bit 15 reads 1, `osc_en` is 1 and the counter runs. Writing 0 to bit 15 does not change this, and neither does asserting `rst_n`.
- R2: While `cfg_force_on` is 0, control bit 15 reads 0 after reset and follows software writes to bit 15. Its value survives sleep, idle and a wake by `irq_wake`.
- R3: While the watchdog is enabled and neither `sleep_mode` nor `idle_mode` is high, the 32·2^N-th tick rising edge after the last clear makes `reset_req` high for exactly one cycle. No status flag is set and `nmi_req` stays low.
- R4: A timeout while `sleep_mode` or `idle_mode` is high makes `nmi_req` high for exactly one cycle and sets status bit 4 (timeout). `reset_req` stays low.
- R5: A timeout in sleep also sets status bit 3 (sleep cause). A timeout in idle with `sleep_mode` low sets status bit 2 (idle cause). When both modes are high, sleep wins.
- R6: The counter returns to zero on reset, on a control write with bit 0 set, on `dbg_clear`, and on `irq_wake`. A clear that falls in the same cycle as the terminal tick wins, so no timeout occurs.
- R7: Going into sleep or idle does not clear the counter. Ticks counted before entry and ticks counted after entry add up toward the same timeout.
- R8: While the watchdog is disabled, the counter stays at zero, ticks are ignored, no pulse is produced and `osc_en` is 0. `osc_en` is 1 whenever the watchdog is enabled.
- R9: Control bits 12:8 select the postscaler N, and the timeout period is 32·2^N ticks. A written value above 20 is stored, and reads back, as 20.
- R10: Status flags are sticky. In a write to the status word, a 0 in a flag's bit clears that flag and a 1 leaves it unchanged. Reset clears all flags.
- R11: Control bit 0 always reads 0.
- R12: Each rising edge of `tick_in` advances the counter once, however long the tick stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low device reset |
| cfg_force_on | input | 1 | Configuration: keep the watchdog permanently enabled |
| tick_in | input | 1 | Slow tick from the low-power oscillator, asynchronous |
| sleep_mode | input | 1 | System is in sleep |
| idle_mode | input | 1 | System is in idle |
| dbg_clear | input | 1 | Debug command: clear the counter |
| irq_wake | input | 1 | Exit from sleep or idle caused by an interrupt: clear the counter |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| reset_req | output | 1 | One-cycle device-reset request |
| nmi_req | output | 1 | One-cycle non-maskable wake interrupt |
| osc_en | output | 1 | Low-power oscillator enable |

## Verification
The risky coincidence is a counter clear that lands in the same cycle as the tick edge that would reach the terminal count. The bench sends the 32nd tick and pulses `dbg_clear` exactly in the cycle where the synchronized edge is presented to the counter. If the clear wins, there is no `reset_req` then, and the next reset request arrives a full 32 ticks later. A second overlap happens when a timeout flag is set in the same cycle that software writes the status word. Here the hardware set takes priority, and an assertion checks that every `nmi_req` is accompanied by a set timeout flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Register word bit positions (software-visible layout)
    localparam int CTRL_EN_BIT  = 15;
    localparam int CTRL_PS_LSB  = 8;
    localparam int CTRL_CLR_BIT = 0;
    localparam int STAT_TO_BIT  = 4;
    localparam int STAT_SLP_BIT = 3;
    localparam int STAT_IDL_BIT = 2;

    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_STAT = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_SLEEP = 2'd2
    } pwr_mode_e;

    // Sleep takes precedence over idle when both are reported
    function automatic pwr_mode_e decode_mode(input logic slp, input logic idl);
        if (slp) return PM_SLEEP;
        if (idl) return PM_IDLE;
        return PM_RUN;
    endfunction

endpackage

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_rise
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], tick_async};
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_rise = st_q.sync[STAGES-1] & ~st_q.last;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise); // R12

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int BASE_W = 5,
    parameter int PS_MAX = 20,
    parameter int PS_W   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            clr,
    input  logic            tick,
    input  logic [PS_W-1:0] ps_sel,
    output logic            expire
);

    localparam int CNT_W = BASE_W + PS_MAX;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] last_val;

    // Terminal value: 32*2^N - 1 (shift past the top wraps to all ones)
    always_comb begin
        last_val = (CNT_ONE << (BASE_W + int'(ps_sel))) - CNT_ONE;
    end

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (!run_en || clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= last_val) begin
                st_d.cnt = '0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0)); // R6

    AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (st_q.cnt == '0)); // R8

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int PS_MAX = 20,
    parameter int PS_W   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_force_on,
    input  logic            sleep_mode,
    input  logic            idle_mode,
    input  logic            bus_wr,
    input  logic            bus_addr,
    input  logic [31:0]     bus_wdata,
    input  logic            expire,
    output logic            en_eff,
    output logic            sw_clear,
    output logic [PS_W-1:0] ps_sel,
    output logic [31:0]     bus_rdata,
    output logic            reset_req,
    output logic            nmi_req
);

    typedef struct packed {
        logic            en;
        logic [PS_W-1:0] ps;
        logic            st_to;
        logic            st_slp;
        logic            st_idl;
        logic            rst_p;
        logic            nmi_p;
    } reg_st_t;

    reg_st_t st_d, st_q;
    reg_sel_e  sel;
    pwr_mode_e mode;
    logic            wr_ctrl, wr_stat;
    logic [PS_W-1:0] ps_wr;
    logic            unused_wdata;

    assign sel          = reg_sel_e'(bus_addr);
    assign mode         = decode_mode(sleep_mode, idle_mode);
    assign wr_ctrl      = bus_wr && (sel == REG_CTRL);
    assign wr_stat      = bus_wr && (sel == REG_STAT);
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        ps_wr = bus_wdata[CTRL_PS_LSB +: PS_W];
        if (ps_wr > PS_W'(PS_MAX)) ps_wr = PS_W'(PS_MAX);
    end

    always_comb begin
        st_d       = st_q;
        st_d.rst_p = 1'b0;
        st_d.nmi_p = 1'b0;
        if (wr_ctrl) begin
            st_d.en = bus_wdata[CTRL_EN_BIT];
            st_d.ps = ps_wr;
        end
        if (wr_stat) begin
            st_d.st_to  = st_q.st_to  & bus_wdata[STAT_TO_BIT];
            st_d.st_slp = st_q.st_slp & bus_wdata[STAT_SLP_BIT];
            st_d.st_idl = st_q.st_idl & bus_wdata[STAT_IDL_BIT];
        end
        // Hardware events override a coincident software write
        if (expire) begin
            unique case (mode)
                PM_SLEEP: begin
                    st_d.nmi_p  = 1'b1;
                    st_d.st_to  = 1'b1;
                    st_d.st_slp = 1'b1;
                end
                PM_IDLE: begin
                    st_d.nmi_p  = 1'b1;
                    st_d.st_to  = 1'b1;
                    st_d.st_idl = 1'b1;
                end
                default: st_d.rst_p = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_eff    = cfg_force_on | st_q.en;
    assign sw_clear  = wr_ctrl && bus_wdata[CTRL_CLR_BIT];
    assign ps_sel    = st_q.ps;
    assign reset_req = st_q.rst_p;
    assign nmi_req   = st_q.nmi_p;

    always_comb begin
        bus_rdata = '0;
        if (sel == REG_CTRL) begin
            bus_rdata[CTRL_EN_BIT]              = en_eff;
            bus_rdata[CTRL_PS_LSB +: PS_W]      = st_q.ps;
        end else begin
            bus_rdata[STAT_TO_BIT]  = st_q.st_to;
            bus_rdata[STAT_SLP_BIT] = st_q.st_slp;
            bus_rdata[STAT_IDL_BIT] = st_q.st_idl;
        end
    end

    AST_RESET_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (!$past(sleep_mode) && !$past(idle_mode))); // R3

    AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req); // R3

    AST_NMI_ONLY_SAVING: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> ($past(sleep_mode) || $past(idle_mode))); // R4

    AST_NMI_FLAGS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> st_q.st_to); // R4

    AST_SLEEP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && $past(sleep_mode)) |-> st_q.st_slp); // R5

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.st_to) && !($past(bus_wr) && ($past(bus_addr) == REG_STAT))) |-> st_q.st_to); // R10

endmodule

// File: rtl/wdt_pwrsave.sv
module wdt_pwrsave #(
    parameter int BASE_W      = 5,
    parameter int PS_MAX      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_force_on,
    input  logic        tick_in,
    input  logic        sleep_mode,
    input  logic        idle_mode,
    input  logic        dbg_clear,
    input  logic        irq_wake,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        reset_req,
    output logic        nmi_req,
    output logic        osc_en
);

    localparam int PS_W = $clog2(PS_MAX + 1);

    logic            tick_rise;
    logic            en_eff;
    logic            sw_clear;
    logic            cnt_clr;
    logic            expire;
    logic [PS_W-1:0] ps_sel;

    wdt_tick_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (tick_in),
        .tick_rise  (tick_rise)
    );

    assign cnt_clr = sw_clear | dbg_clear | irq_wake;

    wdt_count #(
        .BASE_W (BASE_W),
        .PS_MAX (PS_MAX),
        .PS_W   (PS_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (en_eff),
        .clr    (cnt_clr),
        .tick   (tick_rise),
        .ps_sel (ps_sel),
        .expire (expire)
    );

    wdt_regs #(
        .PS_MAX (PS_MAX),
        .PS_W   (PS_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_force_on (cfg_force_on),
        .sleep_mode   (sleep_mode),
        .idle_mode    (idle_mode),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .expire       (expire),
        .en_eff       (en_eff),
        .sw_clear     (sw_clear),
        .ps_sel       (ps_sel),
        .bus_rdata    (bus_rdata),
        .reset_req    (reset_req),
        .nmi_req      (nmi_req)
    );

    assign osc_en = en_eff;

    AST_NO_DOUBLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && nmi_req)); // R4

endmodule

// File: tb/wdt_pwrsave_tb_top.sv
`timescale 1ns/1ps
module wdt_pwrsave_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_force_on;
    logic        tick_in;
    logic        sleep_mode;
    logic        idle_mode;
    logic        dbg_clear;
    logic        irq_wake;
    logic        bus_wr;
    logic        bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        reset_req;
    logic        nmi_req;
    logic        osc_en;

    int n_tests = 0;
    int n_fail  = 0;
    int rst_seen = 0;
    int nmi_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdt_pwrsave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_force_on (cfg_force_on),
        .tick_in      (tick_in),
        .sleep_mode   (sleep_mode),
        .idle_mode    (idle_mode),
        .dbg_clear    (dbg_clear),
        .irq_wake     (irq_wake),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .reset_req    (reset_req),
        .nmi_req      (nmi_req),
        .osc_en       (osc_en)
    );

    always @(negedge clk) begin
        if (reset_req) rst_seen++;
        if (nmi_req)   nmi_seen++;
    end

    // Row: {sleep, idle, ticks[7:0], resets[1:0], nmis[1:0], {to,slp,idl}}
    localparam logic [16:0] VEC [7] = '{
        {1'b0, 1'b0, 8'd31, 2'd0, 2'd0, 3'b000},
        {1'b0, 1'b0, 8'd32, 2'd1, 2'd0, 3'b000},
        {1'b1, 1'b0, 8'd32, 2'd0, 2'd1, 3'b110},
        {1'b0, 1'b1, 8'd32, 2'd0, 2'd1, 3'b101},
        {1'b1, 1'b1, 8'd32, 2'd0, 2'd1, 3'b110},
        {1'b0, 1'b0, 8'd64, 2'd2, 2'd0, 3'b000},
        {1'b1, 1'b0, 8'd31, 2'd0, 2'd0, 3'b000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic give_tick(input int hi);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (hi) @(negedge clk);
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic give_ticks(input int n);
        for (int i = 0; i < n; i++) give_tick(4);
    endtask

    task automatic arm(input int ps);
        bus_write(1'b0, 32'h8001 | (32'(ps) << 8));
    endtask

    task automatic pulse_dbg();
        @(negedge clk); dbg_clear = 1'b1;
        @(negedge clk); dbg_clear = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); irq_wake = 1'b1;
        @(negedge clk); irq_wake = 1'b0;
    endtask

    // Tick whose synchronized edge meets a debug clear in the same cycle
    task automatic tick_with_dbg();
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk);
        @(negedge clk); dbg_clear = 1'b1;
        @(negedge clk); dbg_clear = 1'b0;
        @(negedge clk); tick_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int b_rst, b_nmi;
        rst_n = 1'b0; cfg_force_on = 1'b0; tick_in = 1'b0;
        sleep_mode = 1'b0; idle_mode = 1'b0; dbg_clear = 1'b0; irq_wake = 1'b0;
        bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        bus_read(1'b0, rd); check("R2 ctrl after reset", rd, 32'h0);
        bus_read(1'b1, rd); check("R10 status after reset", rd, 32'h0);
        check("R8 osc_en after reset", {31'b0, osc_en}, 32'h0);

        // Disabled: ticks ignored
        b_rst = rst_seen;
        give_ticks(40);
        check("R8 no reset while disabled", rst_seen - b_rst, 0);

        // Clear bit self-clears, enable drives oscillator
        bus_write(1'b0, 32'h8001);
        bus_read(1'b0, rd); check("R11 clear bit reads 0", rd, 32'h8000);
        check("R8 osc_en when enabled", {31'b0, osc_en}, 32'h1);

        // Vector table
        for (int r = 0; r < 7; r++) begin
            logic [16:0] v;
            v = VEC[r];
            arm(0);
            sleep_mode = v[16]; idle_mode = v[15];
            b_rst = rst_seen; b_nmi = nmi_seen;
            give_ticks(int'(v[14:7]));
            check($sformatf("R3 row %0d reset pulses", r), rst_seen - b_rst, 32'(v[6:5]));
            check($sformatf("R4 row %0d nmi pulses", r), nmi_seen - b_nmi, 32'(v[4:3]));
            bus_read(1'b1, rd);
            check($sformatf("R5 row %0d status", r), 32'(rd[4:2]), 32'(v[2:0]));
            sleep_mode = 1'b0; idle_mode = 1'b0;
            bus_write(1'b1, 32'h0);
        end

        // Postscaler N=1
        arm(1);
        b_rst = rst_seen;
        give_ticks(63);
        check("R9 N=1 no reset at 63", rst_seen - b_rst, 0);
        give_ticks(1);
        check("R9 N=1 reset at 64", rst_seen - b_rst, 1);
        bus_write(1'b0, 32'h8000 | (32'd31 << 8));
        bus_read(1'b0, rd); check("R9 postscaler clamp", 32'(rd[12:8]), 32'd20);

        // Clear sources
        arm(0); b_rst = rst_seen;
        give_ticks(20); bus_write(1'b0, 32'h8001); give_ticks(20);
        check("R6 sw clear delays timeout", rst_seen - b_rst, 0);
        give_ticks(12);
        check("R6 timeout 32 after sw clear", rst_seen - b_rst, 1);

        arm(0); b_rst = rst_seen;
        give_ticks(20); pulse_dbg(); give_ticks(20);
        check("R6 debug clear delays timeout", rst_seen - b_rst, 0);
        give_ticks(12);
        check("R6 timeout 32 after debug clear", rst_seen - b_rst, 1);

        arm(0); b_rst = rst_seen;
        give_ticks(20); pulse_wake(); give_ticks(20);
        check("R6 wake clear delays timeout", rst_seen - b_rst, 0);

        // Clear coinciding with terminal tick
        arm(0); b_rst = rst_seen;
        give_ticks(31); tick_with_dbg();
        check("R6 clear wins over terminal tick", rst_seen - b_rst, 0);
        give_ticks(31);
        check("R6 no reset 31 after collision", rst_seen - b_rst, 0);
        give_ticks(1);
        check("R6 reset 32 after collision", rst_seen - b_rst, 1);

        // Entering sleep keeps the count
        arm(0); b_rst = rst_seen; b_nmi = nmi_seen;
        give_ticks(20); sleep_mode = 1'b1; give_ticks(12);
        check("R7 sleep entry keeps count nmi", nmi_seen - b_nmi, 1);
        check("R7 sleep entry no reset", rst_seen - b_rst, 0);
        sleep_mode = 1'b0;

        // Sticky status, write-0-to-clear
        bus_write(1'b1, 32'h10);
        bus_read(1'b1, rd); check("R10 write 1 keeps, 0 clears", rd, 32'h10);
        bus_write(1'b1, 32'h0);
        bus_read(1'b1, rd); check("R10 status cleared", rd, 32'h0);

        // Enable retained across sleep and interrupt wake
        sleep_mode = 1'b1; pulse_wake(); sleep_mode = 1'b0;
        bus_read(1'b0, rd); check("R2 enable kept over wake", 32'(rd[15]), 32'h1);
        bus_write(1'b0, 32'h0);
        bus_read(1'b0, rd); check("R2 enable cleared by write", 32'(rd[15]), 32'h0);

        // Long-high ticks count once
        arm(0); b_rst = rst_seen;
        for (int i = 0; i < 16; i++) give_tick(20);
        give_ticks(15);
        check("R12 long ticks count once (31)", rst_seen - b_rst, 0);
        give_ticks(1);
        check("R12 long ticks count once (32)", rst_seen - b_rst, 1);

        // Set a flag, then reset with force-on
        arm(0); sleep_mode = 1'b1; give_ticks(32); sleep_mode = 1'b0;
        cfg_force_on = 1'b1;
        bus_write(1'b0, 32'h0);
        bus_read(1'b0, rd); check("R1 write 0 cannot disable", 32'(rd[15]), 32'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 osc_en held in reset", {31'b0, osc_en}, 32'h1);
        rst_n = 1'b1;
        bus_read(1'b0, rd); check("R1 enable survives reset", 32'(rd[15]), 32'h1);
        bus_read(1'b1, rd); check("R10 reset clears status", rd, 32'h0);
        b_rst = rst_seen;
        give_ticks(32);
        check("R1 forced watchdog times out", rst_seen - b_rst, 1);
        cfg_force_on = 1'b0;
        bus_read(1'b0, rd); check("R2 reset cleared soft enable", 32'(rd[15]), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule